// File: doc/BRIEF.md
# Windowed Command and Interrupt-Status Unit

This block is the control front end of a network adapter's 16-bit register space. One offset, the command port, accepts single-word commands. Each command word holds a 5-bit operation code and an 11-bit argument. The commands pick which register bank (window) the rest of the address space shows, turn the receive and transmit paths on or off, load the receive address filter, and load the interrupt and read-view masks. They also acknowledge interrupt sources, start the coax transceiver, reset the transmitter, discard the top receive packet, and set the transmit-room threshold. The banks behind the window and the FIFOs are outside the block. It only provides the selected window number and the control levels and pulses that the datapaths use.

The receive and transmit datapaths send single-cycle event pulses. Each pulse sets a sticky source bit in the status word. The status word is a combinational view of registered state, and it also carries a busy flag and the current window number. An interrupt latch gathers the enabled sources and drives a level interrupt line. Software clears that line by acknowledging the source bits and the latch.

All ports are plain control and status signals. No data stream crosses this block's edge, so no port uses valid/ready handshaking.

Top module: `cmdwin_ctrl`

## Requirements
- R1: A write is decoded as a command only when `wr_en` is high and `wr_addr` equals 0xE. The opcode is `wr_data[15:11]` and the argument is `wr_data[10:0]`. Writes to any other offset, and opcodes not listed below (for example 0x1F), change no output.
- R2: Opcode 0x01 loads argument bits 2:0 into `window_o` in the cycle after the write. The same value appears in status bits 15:13.
- R3: Opcode 0x04 sets `rx_en_o` and 0x03 clears it. Opcode 0x09 sets `tx_en_o` and 0x0A clears it. Opcode 0x0B clears `tx_en_o` and pulses `tx_reset_o` high for one cycle.
- R4: Opcode 0x10 loads argument bits 3:0 into `filter_o`. Bit 0 accepts the station's own address, bit 1 multicast, bit 2 broadcast and bit 3 all frames.
- R5: An event pulse sets a sticky source bit in the status word: `ev_tx_done` sets bit 2, `ev_tx_room` sets bit 3 and `ev_rx_done` sets bit 4.
- R6: Opcode 0x0D clears exactly the status bits 7:0 that are set in its argument, including the latch at bit 0. If an event sets a bit in the same cycle that an acknowledge clears it, the set wins.
- R7: Opcode 0x0E loads the interrupt mask from argument bits 7:0. The latch (status bit 0) sets when an event arrives on a source whose mask bit was already set. `irq_o` is the latch ANDed with any source bit 7:1 whose mask bit is set.
- R8: Opcode 0x0F loads the read-view mask from argument bits 7:0. Status bits 7:0 are reported ANDed with this mask. The mask has no effect on `irq_o`.
- R9: Opcode 0x08 pulses `rx_discard_o` for one cycle. Status bit 12 then reads 1 for DISCARD_CYCLES cycles (default 4) and reads 0 after that. Status bits 11:8 and 7:5 read 0 in the default use.
- R10: Opcode 0x02 pulses `coax_start_o` for one cycle. Opcode 0x12 loads all 11 argument bits into `tx_thresh_o`.
- R11: After reset: window 0, both paths off, filter 0, interrupt mask 0, read-view mask 0xFF, threshold 0x7FF, no sources, latch clear, not busy, and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| ev_rx_done | input | 1 | Receive-complete event pulse |
| ev_tx_done | input | 1 | Transmit-complete event pulse |
| ev_tx_room | input | 1 | Transmit-room event pulse |
| status_o | output | 16 | Status word (window, busy, masked sources, latch) |
| window_o | output | 3 | Selected register window |
| rx_en_o | output | 1 | Receive path enable |
| tx_en_o | output | 1 | Transmit path enable |
| filter_o | output | 4 | Receive address filter |
| tx_thresh_o | output | 11 | Transmit-room threshold |
| coax_start_o | output | 1 | Start-transceiver pulse |
| tx_reset_o | output | 1 | Transmitter reset pulse |
| rx_discard_o | output | 1 | Discard-top-packet pulse |
| irq_o | output | 1 | Interrupt request level |

## Verification
The bench targets an event landing in the same cycle as an acknowledge of that bit. A design that lets the clear win would lose a receive completion for good. It also changes the interrupt mask in the cycle an event arrives, to show whether the latch decision uses the old mask. The bench checks that the read-view mask hides bits from the status word while the interrupt line still follows them; a design that masked the source itself would drop interrupts. Further cases are a write to a non-command offset, an undefined opcode, and a discard reissued while busy, which must restart the busy window and not stack or cut it short.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;
  localparam int OPC_W = 5;
  localparam int ARG_W = 11;
  localparam int SRC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_WINDOW  = 5'h01,
    OP_COAX    = 5'h02,
    OP_RX_OFF  = 5'h03,
    OP_RX_ON   = 5'h04,
    OP_DISCARD = 5'h08,
    OP_TX_ON   = 5'h09,
    OP_TX_OFF  = 5'h0A,
    OP_TX_RST  = 5'h0B,
    OP_ACK     = 5'h0D,
    OP_IMASK   = 5'h0E,
    OP_RZMASK  = 5'h0F,
    OP_FILTER  = 5'h10,
    OP_THRESH  = 5'h12
  } opcode_e;

  typedef struct packed {
    logic win;
    logic coax;
    logic rx_off;
    logic rx_on;
    logic discard;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic ack;
    logic imask;
    logic rzmask;
    logic filter;
    logic thresh;
    logic [ARG_W-1:0] arg;
  } cmd_t;
endpackage

// File: rtl/cmdwin_decode.sv
module cmdwin_decode
  import cmdwin_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CMD_OFFSET = 14
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output cmd_t              cmd
);
  logic hit;
  logic [OPC_W-1:0] opc;

  assign hit = wr_en && (wr_addr == ADDR_W'(CMD_OFFSET));
  assign opc = wr_data[15:11];

  always_comb begin
    cmd     = '0;
    cmd.arg = wr_data[ARG_W-1:0];
    if (hit) begin
      case (opc)
        OP_WINDOW:  cmd.win     = 1'b1;
        OP_COAX:    cmd.coax    = 1'b1;
        OP_RX_OFF:  cmd.rx_off  = 1'b1;
        OP_RX_ON:   cmd.rx_on   = 1'b1;
        OP_DISCARD: cmd.discard = 1'b1;
        OP_TX_ON:   cmd.tx_on   = 1'b1;
        OP_TX_OFF:  cmd.tx_off  = 1'b1;
        OP_TX_RST:  cmd.tx_rst  = 1'b1;
        OP_ACK:     cmd.ack     = 1'b1;
        OP_IMASK:   cmd.imask   = 1'b1;
        OP_RZMASK:  cmd.rzmask  = 1'b1;
        OP_FILTER:  cmd.filter  = 1'b1;
        OP_THRESH:  cmd.thresh  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/cmdwin_irq.sv
module cmdwin_irq #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:1] ev,
  input  logic             ack,
  input  logic [SRC_W-1:0] ack_bits,
  input  logic             load_mask,
  input  logic [SRC_W-1:0] mask_val,
  output logic [SRC_W-1:1] src,
  output logic             latch,
  output logic [SRC_W-1:0] mask,
  output logic             irq
);
  logic [SRC_W-1:0] clr;
  logic             latch_set;

  assign clr       = ack ? ack_bits : '0;
  assign latch_set = |(ev & mask[SRC_W-1:1]);

  for (genvar i = 1; i < SRC_W; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)     src[i] <= 1'b0;
      else if (ev[i]) src[i] <= 1'b1;
      else if (clr[i]) src[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= 1'b0;
      mask  <= '0;
    end else begin
      if (latch_set)   latch <= 1'b1;
      else if (clr[0]) latch <= 1'b0;
      if (load_mask)   mask  <= mask_val;
    end
  end

  assign irq = latch && |(src & mask[SRC_W-1:1]);
endmodule

// File: rtl/cmdwin_busy.sv
module cmdwin_busy #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cmdwin_ctrl.sv
module cmdwin_ctrl
  import cmdwin_pkg::*;
#(
  parameter int DISCARD_CYCLES = 4,
  parameter int CMD_OFFSET     = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        ev_rx_done,
  input  logic        ev_tx_done,
  input  logic        ev_tx_room,
  output logic [15:0] status_o,
  output logic [2:0]  window_o,
  output logic        rx_en_o,
  output logic        tx_en_o,
  output logic [3:0]  filter_o,
  output logic [10:0] tx_thresh_o,
  output logic        coax_start_o,
  output logic        tx_reset_o,
  output logic        rx_discard_o,
  output logic        irq_o
);
  localparam int WIN_W = 3;
  localparam int FLT_W = 4;

  cmd_t             cmd;
  logic [SRC_W-1:1] ev_vec;
  logic [SRC_W-1:1] src_w;
  logic             latch_w;
  logic [SRC_W-1:0] imask_w;
  logic [SRC_W-1:0] rzmask_q;
  logic             busy_w;

  cmdwin_decode #(.ADDR_W(4), .CMD_OFFSET(CMD_OFFSET)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd)
  );

  always_comb begin
    ev_vec    = '0;
    ev_vec[2] = ev_tx_done;
    ev_vec[3] = ev_tx_room;
    ev_vec[4] = ev_rx_done;
  end

  cmdwin_irq #(.SRC_W(SRC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec),
    .ack(cmd.ack), .ack_bits(cmd.arg[SRC_W-1:0]),
    .load_mask(cmd.imask), .mask_val(cmd.arg[SRC_W-1:0]),
    .src(src_w), .latch(latch_w), .mask(imask_w), .irq(irq_o)
  );

  cmdwin_busy #(.CYCLES(DISCARD_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(cmd.discard), .busy(busy_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window_o     <= '0;
      rx_en_o      <= 1'b0;
      tx_en_o      <= 1'b0;
      filter_o     <= '0;
      tx_thresh_o  <= '1;
      rzmask_q     <= '1;
      coax_start_o <= 1'b0;
      tx_reset_o   <= 1'b0;
      rx_discard_o <= 1'b0;
    end else begin
      coax_start_o <= cmd.coax;
      tx_reset_o   <= cmd.tx_rst;
      rx_discard_o <= cmd.discard;
      if (cmd.win)    window_o    <= cmd.arg[WIN_W-1:0];
      if (cmd.rx_on)  rx_en_o     <= 1'b1;
      if (cmd.rx_off) rx_en_o     <= 1'b0;
      if (cmd.tx_on)  tx_en_o     <= 1'b1;
      if (cmd.tx_off || cmd.tx_rst) tx_en_o <= 1'b0;
      if (cmd.filter) filter_o    <= cmd.arg[FLT_W-1:0];
      if (cmd.thresh) tx_thresh_o <= cmd.arg;
      if (cmd.rzmask) rzmask_q    <= cmd.arg[SRC_W-1:0];
    end
  end

  assign status_o = {window_o, busy_w, 4'b0000, ({src_w, latch_w} & rzmask_q)};
endmodule

// File: rtl/cmdwin_ctrl_chk.sv
module cmdwin_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        ev_rx_done,
  input logic [15:0] status_o,
  input logic [2:0]  window_o,
  input logic        irq_o,
  input logic [7:1]  src_w,
  input logic        latch_w
);
  logic cmd_hit;
  assign cmd_hit = wr_en && (wr_addr == 4'hE);

  p_ignored_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != 4'hE) |=> $stable(window_o));

  p_window_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && wr_data[15:11] == 5'h01) |=> (window_o == $past(wr_data[2:0]) && status_o[15:13] == window_o));

  p_rx_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> src_w[4]);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && wr_data[15:11] == 5'h0D && wr_data[4] && !ev_rx_done) |=> !src_w[4]);

  p_irq_needs_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> latch_w);

  p_discard_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && wr_data[15:11] == 5'h08) |=> status_o[12]);
endmodule

bind cmdwin_ctrl cmdwin_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ev_rx_done(ev_rx_done), .status_o(status_o), .window_o(window_o),
  .irq_o(irq_o), .src_w(src_w), .latch_w(latch_w)
);

// File: tb/cmdwin_ctrl_bench.sv
module cmdwin_ctrl_bench;
  localparam int DISC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic ev_rx_done = 1'b0, ev_tx_done = 1'b0, ev_tx_room = 1'b0;
  logic [15:0] status_o;
  logic [2:0] window_o;
  logic rx_en_o, tx_en_o, coax_start_o, tx_reset_o, rx_discard_o, irq_o;
  logic [3:0] filter_o;
  logic [10:0] tx_thresh_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmdwin_ctrl #(.DISCARD_CYCLES(DISC)) u_cmdwin_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_rx_done(ev_rx_done), .ev_tx_done(ev_tx_done), .ev_tx_room(ev_tx_room),
    .status_o(status_o), .window_o(window_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
    .filter_o(filter_o), .tx_thresh_o(tx_thresh_o), .coax_start_o(coax_start_o),
    .tx_reset_o(tx_reset_o), .rx_discard_o(rx_discard_o), .irq_o(irq_o)
  );

  // bench model of the requirements
  logic [2:0]  m_win;
  logic        m_rx, m_tx, m_coax, m_trst, m_disc, m_latch;
  logic [3:0]  m_filt;
  logic [10:0] m_thr;
  logic [7:0]  m_src, m_imask, m_rz;
  int          m_cnt;

  function automatic logic [15:0] exp_status();
    return {m_win, (m_cnt != 0), 4'b0000, ({m_src[7:1], m_latch} & m_rz)};
  endfunction

  function automatic logic exp_irq();
    return m_latch && |(m_src[7:1] & m_imask[7:1]);
  endfunction

  task automatic model_reset();
    m_win = 0; m_rx = 0; m_tx = 0; m_filt = 0; m_thr = 11'h7FF;
    m_src = 0; m_imask = 0; m_rz = 8'hFF; m_latch = 0; m_cnt = 0;
    m_coax = 0; m_trst = 0; m_disc = 0;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 window", 16'(window_o), 16'(m_win));
    chk("R3 rx_en", 16'(rx_en_o), 16'(m_rx));
    chk("R3 tx_en", 16'(tx_en_o), 16'(m_tx));
    chk("R3 tx_reset pulse", 16'(tx_reset_o), 16'(m_trst));
    chk("R4 filter", 16'(filter_o), 16'(m_filt));
    chk("R5/R6/R8/R9 status", status_o, exp_status());
    chk("R7 irq", 16'(irq_o), 16'(exp_irq()));
    chk("R9 discard pulse", 16'(rx_discard_o), 16'(m_disc));
    chk("R10 coax pulse", 16'(coax_start_o), 16'(m_coax));
    chk("R10 threshold", 16'(tx_thresh_o), 16'(m_thr));
  endtask

  // one clock: drive at negedge, model after posedge, compare mid-cycle
  task automatic step(input bit wr, input logic [3:0] a, input logic [15:0] d,
                      input bit rx, input bit tx, input bit room);
    logic [7:0] evv, clr;
    logic [4:0] op;
    logic [10:0] arg;
    bit hit;
    wr_en = wr; wr_addr = a; wr_data = d;
    ev_rx_done = rx; ev_tx_done = tx; ev_tx_room = room;
    @(posedge clk);
    hit = wr && (a == 4'hE);
    op = d[15:11]; arg = d[10:0];
    evv = {3'b000, rx, room, tx, 2'b00};
    clr = (hit && op == 5'h0D) ? arg[7:0] : 8'h00;
    if (|(evv[7:1] & m_imask[7:1])) m_latch = 1;
    else if (clr[0]) m_latch = 0;
    m_src = ((m_src & ~clr) | evv) & 8'hFE;
    if (hit && op == 5'h08) m_cnt = DISC; else if (m_cnt > 0) m_cnt--;
    m_coax = hit && op == 5'h02;
    m_trst = hit && op == 5'h0B;
    m_disc = hit && op == 5'h08;
    if (hit) begin
      case (op)
        5'h01: m_win = arg[2:0];
        5'h03: m_rx = 0;
        5'h04: m_rx = 1;
        5'h09: m_tx = 1;
        5'h0A, 5'h0B: m_tx = 0;
        5'h0E: m_imask = arg[7:0];
        5'h0F: m_rz = arg[7:0];
        5'h10: m_filt = arg[3:0];
        5'h12: m_thr = arg;
        default: ;
      endcase
    end
    #5;
    compare_all();
    @(negedge clk);
    wr_en = 0; ev_rx_done = 0; ev_tx_done = 0; ev_tx_room = 0;
  endtask

  function automatic logic [15:0] mk(input logic [4:0] op, input logic [10:0] arg);
    return {op, arg};
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] ops[14];
    ops = '{5'h01, 5'h02, 5'h03, 5'h04, 5'h08, 5'h09, 5'h0A, 5'h0B,
            5'h0D, 5'h0E, 5'h0F, 5'h10, 5'h12, 5'h1F};
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    #1;
    chk("R11 reset status", status_o, 16'h00FE & 16'h0000);
    chk("R11 reset thresh", 16'(tx_thresh_o), 16'h07FF);
    chk("R11 reset outputs", {9'b0, window_o, rx_en_o, tx_en_o, irq_o, coax_start_o}, 16'h0);
    @(negedge clk);
    // R1 write to non-command offset ignored
    step(1, 4'h4, mk(5'h01, 11'h5), 0, 0, 0);
    chk("R1 other offset ignored", 16'(window_o), 16'h0);
    // R1 undefined opcode ignored
    step(1, 4'hE, mk(5'h1F, 11'h7FF), 0, 0, 0);
    chk("R1 undefined opcode", status_o, 16'h0000);
    // R2 window and R3 enables
    step(1, 4'hE, mk(5'h01, 11'h6), 0, 0, 0);
    step(1, 4'hE, mk(5'h04, 11'h0), 0, 0, 0);
    step(1, 4'hE, mk(5'h09, 11'h0), 0, 0, 0);
    step(1, 4'hE, mk(5'h0B, 11'h0), 0, 0, 0);
    // R7 mask change with event same cycle: old mask (0) decides, no latch
    step(1, 4'hE, mk(5'h0E, 11'h0FF), 1, 0, 0);
    chk("R7 old mask decides latch", 16'(status_o[0]), 16'h0);
    step(0, 4'h0, 16'h0, 1, 0, 0);
    chk("R7 irq raised", 16'(irq_o), 16'h1);
    // R6 ack collides with event: set wins
    step(1, 4'hE, mk(5'h0D, 11'h011), 1, 0, 0);
    chk("R6 set beats clear", 16'(status_o[4]), 16'h1);
    // R8 read-view mask hides bits but irq stays
    step(1, 4'hE, mk(5'h0F, 11'h000), 0, 0, 0);
    chk("R8 status hidden", 16'(status_o[7:0]), 16'h0);
    chk("R8 irq unaffected", 16'(irq_o), 16'h1);
    step(1, 4'hE, mk(5'h0F, 11'h0FF), 0, 0, 0);
    // R9 discard, reissued while busy restarts window
    step(1, 4'hE, mk(5'h08, 11'h0), 0, 0, 0);
    step(0, 4'h0, 16'h0, 0, 0, 0);
    step(1, 4'hE, mk(5'h08, 11'h0), 0, 0, 0);
    for (int i = 0; i < DISC + 1; i++) step(0, 4'h0, 16'h0, 0, 0, 0);
    chk("R9 busy cleared", 16'(status_o[12]), 16'h0);
    // R10 threshold and coax; R4 filter
    step(1, 4'hE, mk(5'h12, 11'h2A5), 0, 0, 0);
    step(1, 4'hE, mk(5'h02, 11'h0), 0, 0, 0);
    step(1, 4'hE, mk(5'h10, 11'h00D), 0, 1, 1);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      bit w;
      logic [3:0] a;
      logic [15:0] d;
      w = ($urandom % 3) != 0;
      a = (($urandom % 6) == 0) ? 4'($urandom) : 4'hE;
      d = {ops[$urandom % 14], 11'($urandom)};
      if (d[15:11] == 5'h0F && ($urandom % 2)) d[7:0] = 8'hFF;
      step(w, a, d, ($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 7) == 0);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule